// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter with Status and User Buffers

This block serialises stereo audio onto a single biphase-mark coded line in the consumer digital audio interface layout. It carries either processed 20-bit PCM or pass-through 16-bit coded words. Every stereo frame is two 32-slot subframes. Each subframe opens with a synchronising preamble, then carries the payload, and closes with validity, user, channel-status and parity bits. Frames are grouped into status blocks of 192.

Five channel-status bytes and a 129-byte user message buffer are loaded through one byte-write port. The channel-status bytes supply the first 40 bits of each status block. The user buffer streams out at one bit per subframe, so each stereo frame takes two bits. A host sets the control bits and loads the buffers. It then presents sample pairs with a strobe and supplies a clock enable at the half-cell rate of 128 times the sample rate. Lowering the enable quiets the line and restarts the framing.

Top module: `spdif_tx`

## Requirements
- R1: While `enable_i` is 0, `sdo_oe_o` and `sdo_o` are 0 one clock later. All framing and pointer state is cleared. The first subframe after `enable_i` rises is the left subframe of block frame 0.
- R2: A subframe is 64 half-cells. The first 8 half-cells are a preamble, sent first-listed-first when the line was low beforehand: 11101000 for the left subframe of block frame 0, 11100010 for other left subframes, 11100100 for right subframes. A block is 192 frames.
- R3: Slots 4 to 31 are biphase-mark cells. The line toggles at the start of every cell, and it toggles again mid-cell when the bit is 1.
- R4: Slot 31 is even parity: slots 4 to 31 hold an even number of ones.
- R5: With `bypass_i` = 0, a subframe carries the 20-bit PCM sample with its LSB in slot 8 and its MSB in slot 27, and slots 4 to 7 are 0. The left sample goes in the left subframe.
- R6: With `bypass_i` = 1, the 16-bit pass word sits in slots 12 to 27 with its LSB in slot 12, and slots 4 to 11 are 0.
- R7: Slot 28 is 0 when `valid_i` = 1 and 1 when `valid_i` = 0.
- R8: Slot 30 of both subframes of block frame f is bit f mod 8 of status byte f/8 for f < 40, and 0 for f >= 40. Status byte k is written with `wr_stat_i` = 1 and `wr_addr_i` = k (0 to 4).
- R9: Slot 29 streams the user buffer LSB first, left subframe before right, and returns to byte 0 after byte 128. User byte k is written with `wr_stat_i` = 0 and `wr_addr_i` = k (0 to 128). The stream starts at byte 0, bit 0 when the enable rises.
- R10: After reset and with no user or status byte written, slots 29 and 30 are 0 in every subframe.
- R11: A pulse on `smp_stb_i` captures all four sample inputs. The captured pair, `bypass_i` and `valid_i` are taken at the first half-cell of the next frame and stay fixed for that whole frame. Input changes without a strobe have no effect.
- R12: The line changes only in cycles where `tick_i` is 1, one half-cell per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Half-cell enable (128 per frame) |
| smp_stb_i | input | 1 | Sample capture strobe |
| pcm_l_i | input | 20 | Left PCM sample |
| pcm_r_i | input | 20 | Right PCM sample |
| pass_l_i | input | 16 | Left pass-through word |
| pass_r_i | input | 16 | Right pass-through word |
| valid_i | input | 1 | 1 marks the data as valid PCM |
| bypass_i | input | 1 | 1 selects pass-through words |
| enable_i | input | 1 | Transmitter enable, 0 quiets and clears |
| wr_en_i | input | 1 | Buffer byte write |
| wr_stat_i | input | 1 | 1 targets status bytes, 0 the user buffer |
| wr_addr_i | input | 8 | Byte address |
| wr_data_i | input | 8 | Byte value |
| sdo_o | output | 1 | Coded serial line |
| sdo_oe_o | output | 1 | Line drive enable |

## Verification
The assertions assume that `tick_i` is the only thing that advances the framing. They also assume that the host keeps the line low before each preamble, which follows from parity when the enable starts from reset. They take it for granted that strobes and buffer writes may arrive in any cycle, while control bits are only read at frame starts. The stimulus holds `bypass_i` and `valid_i` steady within each run. It pulses the strobe in the middle of a right subframe, so the frame boundary at which new data must appear is unambiguous. It also inserts tick gaps so that hold behaviour is exercised.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int AUD_W     = 20;  // payload slots 8..27
  localparam int AUX_W     = 4;   // slots 4..7
  localparam int BODY_W    = 27;  // slots 4..30
  localparam int PRE_HALVES = 8;
  localparam logic [7:0] PAT_B = 8'b11101000;
  localparam logic [7:0] PAT_M = 8'b11100010;
  localparam logic [7:0] PAT_W = 8'b11100100;
  typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_kind_t;
endpackage

// File: rtl/spdif_tx_seq.sv
module spdif_tx_seq #(
  parameter int BLOCK_FRAMES = 192,
  parameter int UBUF_BYTES   = 129,
  localparam int FW = $clog2(BLOCK_FRAMES),
  localparam int UW = $clog2(UBUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  output logic          half_o,
  output logic [4:0]    slot_o,
  output logic          sub_o,
  output logic [FW-1:0] frame_o,
  output logic [2:0]    ubit_o,
  output logic [UW-1:0] uptr_o
);
  logic          half_q, half_d, sub_q, sub_d;
  logic [4:0]    slot_q, slot_d;
  logic [FW-1:0] frame_q, frame_d;
  logic [2:0]    ubit_q, ubit_d;
  logic [UW-1:0] uptr_q, uptr_d;

  always_comb begin
    half_d  = half_q;
    slot_d  = slot_q;
    sub_d   = sub_q;
    frame_d = frame_q;
    ubit_d  = ubit_q;
    uptr_d  = uptr_q;
    if (!en_i) begin
      half_d  = 1'b0;
      slot_d  = '0;
      sub_d   = 1'b0;
      frame_d = '0;
      ubit_d  = '0;
      uptr_d  = '0;
    end else if (tick_i) begin
      half_d = ~half_q;
      if (half_q) begin
        slot_d = slot_q + 5'd1;
        if (slot_q == 5'd31) begin
          sub_d = ~sub_q;
          if (ubit_q == 3'd7) begin
            ubit_d = '0;
            uptr_d = (uptr_q == UW'(UBUF_BYTES - 1)) ? '0 : uptr_q + UW'(1);
          end else begin
            ubit_d = ubit_q + 3'd1;
          end
          if (sub_q)
            frame_d = (frame_q == FW'(BLOCK_FRAMES - 1)) ? '0 : frame_q + FW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      slot_q  <= '0;
      sub_q   <= 1'b0;
      frame_q <= '0;
      ubit_q  <= '0;
      uptr_q  <= '0;
    end else begin
      half_q  <= half_d;
      slot_q  <= slot_d;
      sub_q   <= sub_d;
      frame_q <= frame_d;
      ubit_q  <= ubit_d;
      uptr_q  <= uptr_d;
    end
  end

  assign half_o  = half_q;
  assign slot_o  = slot_q;
  assign sub_o   = sub_q;
  assign frame_o = frame_q;
  assign ubit_o  = ubit_q;
  assign uptr_o  = uptr_q;

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q < FW'(BLOCK_FRAMES)); // R2
  AST_UPTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && tick_i && half_q && slot_q == 5'd31 && ubit_q == 3'd7 &&
    uptr_q == UW'(UBUF_BYTES - 1) |=> uptr_q == '0); // R9
endmodule

// File: rtl/spdif_tx_store.sv
module spdif_tx_store #(
  parameter int CS_BYTES     = 5,
  parameter int UBUF_BYTES   = 129,
  parameter int BLOCK_FRAMES = 192,
  localparam int FW   = $clog2(BLOCK_FRAMES),
  localparam int UW   = $clog2(UBUF_BYTES),
  localparam int CSB  = CS_BYTES * 8,
  localparam int CSIW = $clog2(CSB),
  localparam int UBB  = UBUF_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          wr_stat_i,
  input  logic [7:0]    wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [FW-1:0] frame_i,
  input  logic [UW-1:0] uptr_i,
  input  logic [2:0]    ubit_i,
  output logic          cs_bit_o,
  output logic          u_bit_o
);
  logic [2**CSIW-1:0]   cs_flat;
  logic [2**(UW+3)-1:0] ub_flat;

  for (genvar g = 0; g < CS_BYTES; g++) begin : g_cs
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q <= '0;
      else if (wr_en_i && wr_stat_i && wr_addr_i == 8'(g))
        byte_q <= wr_data_i;
    end
    assign cs_flat[g*8 +: 8] = byte_q;
  end
  assign cs_flat[2**CSIW-1:CSB] = '0;

  for (genvar g = 0; g < UBUF_BYTES; g++) begin : g_ub
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q <= '0;
      else if (wr_en_i && !wr_stat_i && wr_addr_i == 8'(g))
        byte_q <= wr_data_i;
    end
    assign ub_flat[g*8 +: 8] = byte_q;
  end
  assign ub_flat[2**(UW+3)-1:UBB] = '0;

  assign cs_bit_o = (frame_i < FW'(CSB)) & cs_flat[frame_i[CSIW-1:0]];
  assign u_bit_o  = ub_flat[{uptr_i, ubit_i}];
endmodule

// File: rtl/spdif_tx_enc.sv
module spdif_tx_enc
  import spdif_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              half_i,
  input  logic [4:0]        slot_i,
  input  pre_kind_t         pre_sel_i,
  input  logic [BODY_W-1:0] body_i,
  output logic              sdo_o,
  output logic              oe_o
);
  logic       sdo_q, sdo_d, base_q, base_d, oe_q;
  logic       parity, cell_bit, inv, lvl;
  logic [7:0] pat;
  logic [2:0] pidx;

  always_comb begin
    parity   = ^body_i;
    cell_bit = (slot_i == 5'd31) ? parity : body_i[5'(slot_i - 5'd4)];
    unique case (pre_sel_i)
      PRE_B:   pat = PAT_B;
      PRE_M:   pat = PAT_M;
      default: pat = PAT_W;
    endcase
    pidx = {slot_i[1:0], half_i};
    inv  = (slot_i == 5'd0 && !half_i) ? sdo_q : base_q;
    if (slot_i < 5'd4)      lvl = pat[3'd7 - pidx] ^ inv;
    else if (!half_i)       lvl = ~sdo_q;
    else                    lvl = cell_bit ? ~sdo_q : sdo_q;
    sdo_d  = sdo_q;
    base_d = base_q;
    if (!en_i) begin
      sdo_d  = 1'b0;
      base_d = 1'b0;
    end else if (tick_i) begin
      sdo_d = lvl;
      if (slot_i == 5'd0 && !half_i) base_d = sdo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q  <= 1'b0;
      base_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sdo_q  <= sdo_d;
      base_q <= base_d;
      oe_q   <= en_i;
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;

  AST_PRE_BASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && tick_i && slot_i == 5'd0 && !half_i |-> !sdo_q); // R4
  AST_CELL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && tick_i && slot_i >= 5'd4 && !half_i |=> sdo_q != $past(sdo_q)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !oe_q && !sdo_q); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !tick_i |=> $stable(sdo_q)); // R12
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int PASS_W       = 16,
  parameter int CS_BYTES     = 5,
  parameter int UBUF_BYTES   = 129,
  parameter int BLOCK_FRAMES = 192,
  localparam int FW = $clog2(BLOCK_FRAMES),
  localparam int UW = $clog2(UBUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              smp_stb_i,
  input  logic [AUD_W-1:0]  pcm_l_i,
  input  logic [AUD_W-1:0]  pcm_r_i,
  input  logic [PASS_W-1:0] pass_l_i,
  input  logic [PASS_W-1:0] pass_r_i,
  input  logic              valid_i,
  input  logic              bypass_i,
  input  logic              enable_i,
  input  logic              wr_en_i,
  input  logic              wr_stat_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic              half, sub, cs_bit, u_bit, load;
  logic [4:0]        slot;
  logic [FW-1:0]     frame;
  logic [2:0]        ubit;
  logic [UW-1:0]     uptr;
  logic [AUD_W-1:0]  pend_l_q, pend_l_d, pend_r_q, pend_r_d;
  logic [PASS_W-1:0] pend_pl_q, pend_pl_d, pend_pr_q, pend_pr_d;
  logic [AUD_W-1:0]  act_l_q, act_l_d, act_r_q, act_r_d, pay;
  logic              ctl_v_q, ctl_v_d;
  logic [BODY_W-1:0] body;
  pre_kind_t         pre_sel;

  spdif_tx_seq #(.BLOCK_FRAMES(BLOCK_FRAMES), .UBUF_BYTES(UBUF_BYTES)) i_seq (
    .clk(clk), .rst_n(rst_n), .en_i(enable_i), .tick_i(tick_i),
    .half_o(half), .slot_o(slot), .sub_o(sub), .frame_o(frame),
    .ubit_o(ubit), .uptr_o(uptr));

  spdif_tx_store #(.CS_BYTES(CS_BYTES), .UBUF_BYTES(UBUF_BYTES),
                   .BLOCK_FRAMES(BLOCK_FRAMES)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_stat_i(wr_stat_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .frame_i(frame),
    .uptr_i(uptr), .ubit_i(ubit), .cs_bit_o(cs_bit), .u_bit_o(u_bit));

  always_comb begin
    pend_l_d  = pend_l_q;
    pend_r_d  = pend_r_q;
    pend_pl_d = pend_pl_q;
    pend_pr_d = pend_pr_q;
    if (smp_stb_i) begin
      pend_l_d  = pcm_l_i;
      pend_r_d  = pcm_r_i;
      pend_pl_d = pass_l_i;
      pend_pr_d = pass_r_i;
    end
    load    = enable_i && tick_i && slot == 5'd0 && !half && !sub;
    act_l_d = act_l_q;
    act_r_d = act_r_q;
    ctl_v_d = ctl_v_q;
    if (load) begin
      act_l_d = bypass_i ? {pend_pl_q, {(AUD_W-PASS_W){1'b0}}} : pend_l_q;
      act_r_d = bypass_i ? {pend_pr_q, {(AUD_W-PASS_W){1'b0}}} : pend_r_q;
      ctl_v_d = valid_i;
    end
    pay     = sub ? act_r_q : act_l_q;
    body    = {cs_bit, u_bit, ~ctl_v_q, pay, {AUX_W{1'b0}}};
    pre_sel = sub ? PRE_W : ((frame == '0) ? PRE_B : PRE_M);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q  <= '0;
      pend_r_q  <= '0;
      pend_pl_q <= '0;
      pend_pr_q <= '0;
      act_l_q   <= '0;
      act_r_q   <= '0;
      ctl_v_q   <= 1'b0;
    end else begin
      pend_l_q  <= pend_l_d;
      pend_r_q  <= pend_r_d;
      pend_pl_q <= pend_pl_d;
      pend_pr_q <= pend_pr_d;
      act_l_q   <= act_l_d;
      act_r_q   <= act_r_d;
      ctl_v_q   <= ctl_v_d;
    end
  end

  spdif_tx_enc i_enc (
    .clk(clk), .rst_n(rst_n), .en_i(enable_i), .tick_i(tick_i),
    .half_i(half), .slot_i(slot), .pre_sel_i(pre_sel), .body_i(body),
    .sdo_o(sdo_o), .oe_o(sdo_oe_o));

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_l_q) && $stable(act_r_q) && $stable(ctl_v_q)); // R11
endmodule

// File: tb/test_spdif_tx.sv
`timescale 1ns/1ps
module test_spdif_tx;
  logic        clk = 1'b0;
  logic        rst_n, tick_i, smp_stb_i, valid_i, bypass_i, enable_i;
  logic [19:0] pcm_l_i, pcm_r_i;
  logic [15:0] pass_l_i, pass_r_i;
  logic        wr_en_i, wr_stat_i;
  logic [7:0]  wr_addr_i, wr_data_i;
  logic        sdo_o, sdo_oe_o;

  spdif_tx i_spdif_tx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .smp_stb_i(smp_stb_i),
    .pcm_l_i(pcm_l_i), .pcm_r_i(pcm_r_i), .pass_l_i(pass_l_i), .pass_r_i(pass_r_i),
    .valid_i(valid_i), .bypass_i(bypass_i), .enable_i(enable_i),
    .wr_en_i(wr_en_i), .wr_stat_i(wr_stat_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [7:0]  cs_m [5];
  logic [7:0]  ub_m [129];
  logic [19:0] exp_l, exp_r, nxt_l, nxt_r;
  logic        exp_v, last_lvl, gap_mode;
  int          fcount, stb_frame;
  string       tag_pay, tag_u, tag_c;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input bit stat, input int addr, input logic [7:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_stat_i = stat; wr_addr_i = 8'(addr); wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (stat) begin if (addr < 5) cs_m[addr] = data; end
    else if (addr < 129) ub_m[addr] = data;
  endtask

  task automatic load_pair(input logic [19:0] l, input logic [19:0] r,
                           input logic [15:0] pl, input logic [15:0] pr);
    @(negedge clk);
    pcm_l_i = l; pcm_r_i = r; pass_l_i = pl; pass_r_i = pr; smp_stb_i = 1'b1;
    @(negedge clk);
    smp_stb_i = 1'b0;
  endtask

  task automatic next_half(output logic lvl);
    if (gap_mode) begin
      tick_i = 1'b0;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(sdo_o == last_lvl, "R12 hold without tick", sdo_o, last_lvl);
      end
      tick_i = 1'b1;
    end
    @(negedge clk);
    lvl = sdo_o;
    last_lvl = lvl;
  endtask

  task automatic decode_sub(input int gf, input bit sub);
    logic        h [64];
    logic [31:0] bits;
    logic [7:0]  pre, pat;
    logic        start_lvl, bmc_ok;
    int          bf, s, ub;
    start_lvl = last_lvl;
    bits = '0;
    for (int i = 0; i < 64; i++) begin
      if (stb_frame == gf && sub && i == 10) begin
        pcm_l_i = nxt_l; pcm_r_i = nxt_r; smp_stb_i = 1'b1;
      end
      next_half(h[i]);
      smp_stb_i = 1'b0;
    end
    bf = gf % 192;
    for (int i = 0; i < 8; i++) pre[7-i] = h[i];
    pat = sub ? 8'b11100100 : (bf == 0 ? 8'b11101000 : 8'b11100010);
    chk(pre == (pat ^ {8{start_lvl}}), "R2 preamble", pre, pat ^ {8{start_lvl}});
    bmc_ok = 1'b1;
    for (int sl = 4; sl < 32; sl++) begin
      if (h[2*sl] == h[2*sl-1]) bmc_ok = 1'b0;
      bits[sl] = h[2*sl] ^ h[2*sl+1];
    end
    chk(bmc_ok, "R3 cell edges", bmc_ok, 1);
    chk(^bits[31:4] == 1'b0, "R4 parity", ^bits[31:4], 0);
    chk(bits[27:4] == {(sub ? exp_r : exp_l), 4'b0}, tag_pay,
        bits[27:4], {(sub ? exp_r : exp_l), 4'b0});
    chk(bits[28] == ~exp_v, "R7 validity", bits[28], ~exp_v);
    s  = 2 * gf + int'(sub);
    ub = (s / 8) % 129;
    chk(bits[29] == ub_m[ub][s%8], tag_u, bits[29], ub_m[ub][s%8]);
    chk(bits[30] == ((bf < 40) ? cs_m[bf/8][bf%8] : 1'b0), tag_c,
        bits[30], (bf < 40) ? cs_m[bf/8][bf%8] : 1'b0);
  endtask

  task automatic run_frames(input int n);
    for (int f = 0; f < n; f++) begin
      if (stb_frame >= 0 && fcount == stb_frame + 1) begin exp_l = nxt_l; exp_r = nxt_r; end
      decode_sub(fcount, 1'b0);
      decode_sub(fcount, 1'b1);
      fcount++;
    end
  endtask

  task automatic start_tx();
    @(negedge clk);
    tick_i = 1'b1; enable_i = 1'b1;
    fcount = 0; last_lvl = 1'b0;
  endtask

  task automatic stop_tx();
    @(negedge clk);
    enable_i = 1'b0;
    @(negedge clk);
    chk(!sdo_oe_o && !sdo_o, "R1 disabled quiet", {sdo_oe_o, sdo_o}, 0);
  endtask

  task automatic t_reset();
    chk(!sdo_oe_o && !sdo_o, "R1 reset state", {sdo_oe_o, sdo_o}, 0);
  endtask

  task automatic t_empty();
    tag_u = "R10 empty user"; tag_c = "R10 empty status"; tag_pay = "R5 pcm";
    load_pair(20'h12345, 20'hABCDE, 16'h0, 16'h0);
    exp_l = 20'h12345; exp_r = 20'hABCDE;
    start_tx();
    run_frames(6);
    stop_tx();
  endtask

  task automatic t_main();
    tag_u = "R9 user stream"; tag_c = "R8 status"; tag_pay = "R5 pcm";
    wr_byte(1, 0, 8'h8D); wr_byte(1, 1, 8'h12); wr_byte(1, 2, 8'h7E);
    wr_byte(1, 3, 8'hC3); wr_byte(1, 4, 8'h5A);
    wr_byte(0, 0, 8'hA5); wr_byte(0, 1, 8'h3C); wr_byte(0, 64, 8'h81);
    wr_byte(0, 128, 8'hF0);
    load_pair(20'h80001, 20'h7FFFE, 16'h0, 16'h0);
    exp_l = 20'h80001; exp_r = 20'h7FFFE;
    start_tx();
    run_frames(520);   // three block starts and a user wrap
    stop_tx();
  endtask

  task automatic t_restart();
    tag_u = "R1 R9 restart"; tag_c = "R8 status"; tag_pay = "R5 pcm";
    start_tx();
    run_frames(1);
    for (int i = 0; i < 37; i++) begin logic d; next_half(d); end
    stop_tx();
    start_tx();
    run_frames(2);
    stop_tx();
  endtask

  task automatic t_bypass();
    tag_pay = "R6 pass words"; tag_u = "R9 user stream";
    bypass_i = 1'b1;
    load_pair(20'hFFFFF, 20'hFFFFF, 16'hBEEF, 16'h1234);
    exp_l = {16'hBEEF, 4'h0}; exp_r = {16'h1234, 4'h0};
    start_tx();
    run_frames(3);
    stop_tx();
    bypass_i = 1'b0;
  endtask

  task automatic t_invalid();
    tag_pay = "R5 pcm";
    valid_i = 1'b0; exp_v = 1'b0;
    load_pair(20'h00F0F, 20'hF0F00, 16'h0, 16'h0);
    exp_l = 20'h00F0F; exp_r = 20'hF0F00;
    start_tx();
    run_frames(2);
    stop_tx();
    valid_i = 1'b1; exp_v = 1'b1;
  endtask

  task automatic t_strobe();
    tag_pay = "R11 sample latch";
    load_pair(20'h11111, 20'h22222, 16'h0, 16'h0);
    exp_l = 20'h11111; exp_r = 20'h22222;
    @(negedge clk);
    pcm_l_i = 20'h99999; pcm_r_i = 20'h88888;  // no strobe: must not appear
    nxt_l = 20'h5A5A5; nxt_r = 20'hA5A5A;
    stb_frame = 1;
    start_tx();
    run_frames(4);
    stop_tx();
    stb_frame = -1;
  endtask

  task automatic t_gap();
    tag_pay = "R5 pcm";
    gap_mode = 1'b1;
    start_tx();
    run_frames(2);
    stop_tx();
    gap_mode = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b1; smp_stb_i = 1'b0; valid_i = 1'b1; bypass_i = 1'b0;
    enable_i = 1'b0; wr_en_i = 1'b0; wr_stat_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    pcm_l_i = '0; pcm_r_i = '0; pass_l_i = '0; pass_r_i = '0;
    exp_v = 1'b1; gap_mode = 1'b0; stb_frame = -1; last_lvl = 1'b0; fcount = 0;
    nxt_l = '0; nxt_r = '0;
    for (int i = 0; i < 5; i++) cs_m[i] = '0;
    for (int i = 0; i < 129; i++) ub_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_main();
    t_restart();
    t_bypass();
    t_invalid();
    t_strobe();
    t_gap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule